// File: doc/BRIEF.md
# Branch and Jump Target Unit

This block computes the program counter of the next instruction for a 64-bit core whose instructions are all four bytes long. It owns the PC register. Each cycle that `instr_valid` is high, the decoded control class of the current instruction, a 21-bit signed word displacement, the value of the register under test and a register-held jump address are combined into a next PC, a taken flag, a return address and a write enable for that return address. On the clock edge the PC register then loads the next PC.

Three kinds of control transfer are handled. The first is a conditional branch, which tests the low bit of a register or compares the register as a signed number against zero. The second is an unconditional branch that always saves its return address. The third is a register-indirect jump that also saves its return address. There is no delay slot, so the instruction fetched after a taken transfer is the one at the target. The hint bits that some encodings carry for branch prediction are accepted and then discarded.

Top module: `bju_next_pc`

## Requirements
- R1: After reset, `pc` equals the `RESET_VEC` parameter (default 0x0000_0000_2000_0000). Bits [1:0] of `pc` are zero at all times.
- R2: The PC register loads `next_pc` only on a clock edge where `instr_valid` is high, and otherwise holds its value. While `instr_valid` is low, `taken` and `link_we` are 0 and `next_pc` is `pc`+4. When `op_class` is 0 (not a control instruction), `next_pc` is `pc`+4 and `taken` is 0.
- R3: The target of a branch is `pc` + 4 + (the sign-extended `disp` shifted left by two bits). This covers the extremes 0x0FFFFF and 0x100000.
- R4: When `op_class` is 1 (conditional), `cond_sel` selects the test. The codes are 0 low bit clear, 1 equal to zero, 2 less than zero, 3 less than or equal to zero, 4 low bit set, 5 not zero, 6 greater than or equal to zero and 7 greater than zero, with all comparisons signed on `test_val`. When the test holds, `taken`=1 and `next_pc` is the branch target. Otherwise `taken`=0 and `next_pc` is `pc`+4.
- R5: When `op_class` is 2 (unconditional), `taken`=1 and `next_pc` is the branch target, whatever `test_val` holds.
- R6: When `op_class` is 3 (jump), `taken`=1 and `next_pc` is `jump_val` with bits [1:0] cleared.
- R7: `link_val` always equals `pc`+4. `link_we` is 1 exactly when `instr_valid` is high, `op_class` is 2 or 3, and `link_idx` is not 31. A conditional branch never raises `link_we`.
- R8: The `hint` input has no effect on any output or on the PC.
- R9: All PC arithmetic wraps modulo 2^64 and raises no fault.
- R10: After a taken transfer has been accepted, `pc` holds the target on the next cycle, so no delay-slot instruction sits between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Current instruction accepted this cycle |
| op_class | input | 2 | 0 none, 1 conditional, 2 unconditional, 3 jump |
| cond_sel | input | 3 | Condition code for conditional branches |
| disp | input | 21 | Signed word displacement |
| test_val | input | 64 | Value of the register under test |
| jump_val | input | 64 | Register value supplying the jump address |
| link_idx | input | 5 | Destination register index for the return address |
| hint | input | 14 | Prediction hint bits, ignored |
| pc | output | 64 | Current program counter |
| next_pc | output | 64 | Address of the next instruction |
| taken | output | 1 | Control transfer taken |
| link_val | output | 64 | Return address |
| link_we | output | 1 | Write enable for the return address |

## Verification
Each of the eight conditions is tried against zero, one, minus one, two, minus two and the most negative value. This separates the sign, zero and low-bit paths and catches a swapped inverse pair. Forward and backward displacements, including both extreme values, expose sign-extension and shift mistakes. Jumps with the low address bits set, together with pairs of transfers that differ only in their hint bits, show the alignment masking and that the hint is ignored. A jump to the top of the address space followed by a step, and a backward branch from address zero, exercise the wrap in both directions.

// File: rtl/bju_pkg.sv
package bju_pkg;

   typedef enum logic [1:0] {
      OPC_NONE   = 2'd0,
      OPC_COND   = 2'd1,
      OPC_UNCOND = 2'd2,
      OPC_JUMP   = 2'd3
   } bju_opc_e;

   // bit 2 of a condition code inverts the base test selected by bits [1:0]
   typedef enum logic [2:0] {
      CC_BIT_CLR = 3'd0,
      CC_EQZ     = 3'd1,
      CC_LTZ     = 3'd2,
      CC_LEZ     = 3'd3,
      CC_BIT_SET = 3'd4,
      CC_NEZ     = 3'd5,
      CC_GEZ     = 3'd6,
      CC_GTZ     = 3'd7
   } bju_cc_e;

   localparam int INSTR_BYTES = 4;

endpackage

// File: rtl/bju_cond_eval.sv
module bju_cond_eval
   import bju_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter bit ZERO_TREE = 1'b1,
   parameter int ZT_CHUNK  = 8
) (
   input  logic [XLEN-1:0] val,
   input  logic [2:0]      cc,
   output logic            hit
);

   localparam int NCHUNK = (XLEN + ZT_CHUNK - 1) / ZT_CHUNK;

   logic is_zero;
   logic is_neg;
   logic base;

   generate
      if (ZERO_TREE) begin : g_tree
         logic [NCHUNK-1:0] part_any;
         for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
            if ((g + 1) * ZT_CHUNK <= XLEN) begin : g_full
               assign part_any[g] = |val[g*ZT_CHUNK +: ZT_CHUNK];
            end else begin : g_tail
               assign part_any[g] = |val[XLEN-1:g*ZT_CHUNK];
            end
         end
         assign is_zero = ~|part_any;
      end else begin : g_flat
         assign is_zero = ~|val;
      end
   endgenerate

   assign is_neg = val[XLEN-1];

   always_comb begin
      unique case (cc[1:0])
         2'd0:    base = ~val[0];
         2'd1:    base = is_zero;
         2'd2:    base = is_neg;
         default: base = is_neg | is_zero;
      endcase
   end

   assign hit = base ^ cc[2];

endmodule

// File: rtl/bju_target_calc.sv
module bju_target_calc #(
   parameter int XLEN         = 64,
   parameter int DISP_W       = 21,
   parameter bit PARALLEL_ADD = 1'b1
) (
   input  logic [XLEN-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-1:0]   jump_val,
   output logic [XLEN-1:0]   pc_seq,
   output logic [XLEN-1:0]   br_tgt,
   output logic [XLEN-1:0]   jmp_tgt
);

   localparam int               EXT_W = XLEN - DISP_W - 2;
   localparam logic [XLEN-1:0] STEP  = XLEN'(bju_pkg::INSTR_BYTES);

   logic [XLEN-1:0] off;
   logic            jv_unused;

   assign off    = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
   assign pc_seq = pc + STEP;

   generate
      if (PARALLEL_ADD) begin : g_par
         // three-operand sum, independent of the pc_seq adder
         assign br_tgt = pc + off + STEP;
      end else begin : g_ser
         assign br_tgt = pc_seq + off;
      end
   endgenerate

   assign jmp_tgt   = {jump_val[XLEN-1:2], 2'b00};
   assign jv_unused = ^jump_val[1:0];

endmodule

// File: rtl/bju_pc_reg.sv
module bju_pc_reg #(
   parameter int              XLEN      = 64,
   parameter logic [XLEN-1:0] RESET_VEC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [XLEN-1:0] d,
   output logic [XLEN-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RESET_VEC;
      end else if (load) begin
         q <= d;
      end
   end

endmodule

// File: rtl/bju_next_pc.sv
module bju_next_pc
   import bju_pkg::*;
#(
   parameter int              XLEN         = 64,
   parameter int              DISP_W       = 21,
   parameter int              HINT_W       = 14,
   parameter int              RIDX_W       = 5,
   parameter int              ZERO_IDX     = 31,
   parameter logic [XLEN-1:0] RESET_VEC    = 64'h0000_0000_2000_0000,
   parameter bit              PARALLEL_ADD = 1'b1,
   parameter bit              ZERO_TREE    = 1'b1,
   parameter int              ZT_CHUNK     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [1:0]        op_class,
   input  logic [2:0]        cond_sel,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-1:0]   test_val,
   input  logic [XLEN-1:0]   jump_val,
   input  logic [RIDX_W-1:0] link_idx,
   input  logic [HINT_W-1:0] hint,
   output logic [XLEN-1:0]   pc,
   output logic [XLEN-1:0]   next_pc,
   output logic              taken,
   output logic [XLEN-1:0]   link_val,
   output logic              link_we
);

   localparam logic [RIDX_W-1:0] ZERO_REG = RIDX_W'(ZERO_IDX);

   generate
      if (XLEN <= DISP_W + 2) begin : g_bad_xlen
         $error("XLEN must exceed DISP_W + 2");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("RESET_VEC must be word aligned");
      end
      if (ZT_CHUNK < 1 || ZT_CHUNK > XLEN) begin : g_bad_chunk
         $error("ZT_CHUNK out of range");
      end
      if (ZERO_IDX < 0 || ZERO_IDX >= (1 << RIDX_W)) begin : g_bad_zidx
         $error("ZERO_IDX does not fit RIDX_W");
      end
   endgenerate

   bju_opc_e        opc;
   logic            cond_hit;
   logic            is_link_op;
   logic            take_raw;
   logic [XLEN-1:0] pc_seq;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jmp_tgt;
   logic            hint_unused;

   assign opc         = bju_opc_e'(op_class);
   assign hint_unused = ^hint;

   bju_cond_eval #(
      .XLEN      (XLEN),
      .ZERO_TREE (ZERO_TREE),
      .ZT_CHUNK  (ZT_CHUNK)
   ) u_cond (
      .val (test_val),
      .cc  (cond_sel),
      .hit (cond_hit)
   );

   bju_target_calc #(
      .XLEN         (XLEN),
      .DISP_W       (DISP_W),
      .PARALLEL_ADD (PARALLEL_ADD)
   ) u_tgt (
      .pc       (pc),
      .disp     (disp),
      .jump_val (jump_val),
      .pc_seq   (pc_seq),
      .br_tgt   (br_tgt),
      .jmp_tgt  (jmp_tgt)
   );

   always_comb begin
      unique case (opc)
         OPC_COND:   take_raw = cond_hit;
         OPC_UNCOND: take_raw = 1'b1;
         OPC_JUMP:   take_raw = 1'b1;
         default:    take_raw = 1'b0;
      endcase
   end

   assign is_link_op = (opc == OPC_UNCOND) || (opc == OPC_JUMP);
   assign taken      = instr_valid & take_raw;
   assign link_we    = instr_valid & is_link_op & (link_idx != ZERO_REG);
   assign link_val   = pc_seq;

   always_comb begin
      if (!taken) begin
         next_pc = pc_seq;
      end else if (opc == OPC_JUMP) begin
         next_pc = jmp_tgt;
      end else begin
         next_pc = br_tgt;
      end
   end

   bju_pc_reg #(
      .XLEN      (XLEN),
      .RESET_VEC (RESET_VEC)
   ) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (instr_valid),
      .d     (next_pc),
      .q     (pc)
   );

endmodule

// File: rtl/bju_next_pc_chk.sv
module bju_next_pc_chk #(
   parameter int XLEN     = 64,
   parameter int RIDX_W   = 5,
   parameter int ZERO_IDX = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_valid,
   input logic [1:0]        op_class,
   input logic [XLEN-1:0]   jump_val,
   input logic [RIDX_W-1:0] link_idx,
   input logic [XLEN-1:0]   pc,
   input logic [XLEN-1:0]   next_pc,
   input logic              taken,
   input logic [XLEN-1:0]   link_val,
   input logic              link_we
);

   localparam logic [XLEN-1:0]   MASK_LO  = ~XLEN'(3);
   localparam logic [RIDX_W-1:0] ZERO_REG = RIDX_W'(ZERO_IDX);

   assert_pc_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pc[1:0] == 2'b00);

   assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> $stable(pc));

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> (!taken && !link_we));

   assert_uncond_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && op_class == 2'd2) |-> taken);

   assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && op_class == 2'd3) |-> (taken && next_pc == (jump_val & MASK_LO)));

   assert_cond_no_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_class == 2'd1 || op_class == 2'd0) |-> !link_we);

   assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (link_idx != ZERO_REG));

   assert_link_val_R7: assert property (@(posedge clk) disable iff (!rst_n)
      link_val == pc + XLEN'(4));

   assert_pc_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid |=> (pc == $past(next_pc)));

endmodule

bind bju_next_pc bju_next_pc_chk #(
   .XLEN     (XLEN),
   .RIDX_W   (RIDX_W),
   .ZERO_IDX (ZERO_IDX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .op_class    (op_class),
   .jump_val    (jump_val),
   .link_idx    (link_idx),
   .pc          (pc),
   .next_pc     (next_pc),
   .taken       (taken),
   .link_val    (link_val),
   .link_we     (link_we)
);

// File: tb/bju_next_pc_bench.sv
`timescale 1ns/100ps
module bju_next_pc_bench;

   localparam logic [63:0] RVEC = 64'h0000_0000_2000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [1:0]  op_class = '0;
   logic [2:0]  cond_sel = '0;
   logic [20:0] disp = '0;
   logic [63:0] test_val = '0;
   logic [63:0] jump_val = '0;
   logic [4:0]  link_idx = '0;
   logic [13:0] hint = '0;
   logic [63:0] pc, next_pc, link_val;
   logic        taken, link_we;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [63:0] pc;
      logic [63:0] nxt;
      logic [63:0] lnk;
      logic        tk;
      logic        we;
      string       req;
   } item_t;

   item_t       sb_q[$];
   logic [63:0] model_pc;

   always #2.5 clk = ~clk;

   bju_next_pc u_bju_next_pc (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op_class(op_class),
      .cond_sel(cond_sel), .disp(disp), .test_val(test_val), .jump_val(jump_val),
      .link_idx(link_idx), .hint(hint), .pc(pc), .next_pc(next_pc),
      .taken(taken), .link_val(link_val), .link_we(link_we)
   );

   function automatic logic cond_true(input logic [2:0] cc, input logic [63:0] v);
      logic signed [63:0] s;
      s = v;
      case (cc)
         3'd0: return v[0] == 1'b0;
         3'd1: return s == 0;
         3'd2: return s < 0;
         3'd3: return s <= 0;
         3'd4: return v[0] == 1'b1;
         3'd5: return s != 0;
         3'd6: return s >= 0;
         default: return s > 0;
      endcase
   endfunction

   task automatic drive(input logic v, input logic [1:0] opc, input logic [2:0] cc,
                        input logic [20:0] d, input logic [63:0] tv, input logic [63:0] jv,
                        input logic [4:0] li, input logic [13:0] h, input string req);
      item_t       it;
      logic [63:0] off;
      logic        tk;
      @(negedge clk);
      instr_valid = v; op_class = opc; cond_sel = cc; disp = d;
      test_val = tv; jump_val = jv; link_idx = li; hint = h;
      off = {{41{d[20]}}, d, 2'b00};
      case (opc)
         2'd1:    tk = cond_true(cc, tv);
         2'd2:    tk = 1'b1;
         2'd3:    tk = 1'b1;
         default: tk = 1'b0;
      endcase
      tk = tk & v;
      it.pc  = model_pc;
      it.lnk = model_pc + 64'd4;
      it.tk  = tk;
      it.we  = v && (opc == 2'd2 || opc == 2'd3) && (li != 5'd31);
      if (!tk)               it.nxt = model_pc + 64'd4;
      else if (opc == 2'd3)  it.nxt = jv & ~64'd3;
      else                   it.nxt = model_pc + 64'd4 + off;
      it.req = req;
      sb_q.push_back(it);
      if (v) model_pc = it.nxt;
   endtask

   // monitor: compare outputs 1 ns after each falling edge
   always @(negedge clk) begin
      #1;
      if (sb_q.size() != 0) begin
         item_t e;
         e = sb_q.pop_front();
         checks++;
         if (pc !== e.pc || next_pc !== e.nxt || taken !== e.tk ||
             link_val !== e.lnk || link_we !== e.we) begin
            errors++;
            $display("FAIL %s: pc=%h next=%h tk=%b link=%h we=%b expected pc=%h next=%h tk=%b link=%h we=%b",
                     e.req, pc, next_pc, taken, link_val, link_we,
                     e.pc, e.nxt, e.tk, e.lnk, e.we);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] vals[6];
      vals[0] = 64'd0; vals[1] = 64'd1; vals[2] = '1;
      vals[3] = 64'd2; vals[4] = -64'sd2; vals[5] = 64'h8000_0000_0000_0000;
      model_pc = RVEC;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      checks++;
      if (pc !== RVEC) begin
         errors++;
         $display("FAIL R1: reset pc=%h expected %h", pc, RVEC);
      end

      // R2: plain instructions and idle cycles
      drive(1, 2'd0, 3'd0, 21'd7, 64'd0, 64'd0, 5'd4, 14'd0, "R2");
      drive(1, 2'd0, 3'd1, 21'd9, 64'd0, 64'd0, 5'd4, 14'd0, "R2");
      drive(0, 2'd3, 3'd0, 21'd0, 64'd0, 64'h40, 5'd4, 14'd0, "R2");
      drive(0, 2'd1, 3'd1, 21'd5, 64'd0, 64'd0, 5'd4, 14'd0, "R2");

      // R4 / R3: every condition against signed and low-bit corner values
      for (int c = 0; c < 8; c++) begin
         for (int k = 0; k < 6; k++) begin
            drive(1, 2'd1, 3'(c), (k % 2 == 0) ? 21'd5 : -21'sd3, vals[k], 64'd0,
                  5'd9, 14'd0, "R4");
         end
      end

      // R3: displacement extremes
      drive(1, 2'd1, 3'd1, 21'h0FFFFF, 64'd0, 64'd0, 5'd9, 14'd0, "R3");
      drive(1, 2'd1, 3'd1, 21'h100000, 64'd0, 64'd0, 5'd9, 14'd0, "R3");

      // R5 / R7: unconditional with link, and to the zero register
      drive(1, 2'd2, 3'd1, 21'd12, 64'd5, 64'd0, 5'd26, 14'd0, "R5");
      drive(1, 2'd2, 3'd0, -21'sd8, 64'd0, 64'd0, 5'd31, 14'd0, "R7");
      drive(1, 2'd1, 3'd1, 21'd3, 64'd0, 64'd0, 5'd26, 14'd0, "R7");

      // R8: same transfer with different hints
      drive(1, 2'd2, 3'd0, 21'd20, 64'd0, 64'd0, 5'd26, 14'h0000, "R8");
      drive(1, 2'd2, 3'd0, 21'd20, 64'd0, 64'd0, 5'd26, 14'h3FFF, "R8");

      // R6: jumps with unaligned register values
      drive(1, 2'd3, 3'd0, 21'd0, 64'd0, 64'h1234_5678_9ABC_DEF3, 5'd3, 14'h0000, "R6");
      drive(1, 2'd3, 3'd0, 21'd0, 64'd0, 64'h0000_0000_0000_1001, 5'd3, 14'h2AAA, "R8");

      // R10: next accepted instruction sits at the target
      drive(1, 2'd3, 3'd0, 21'd0, 64'd0, 64'h0000_0000_0040_0000, 5'd1, 14'd0, "R10");
      drive(1, 2'd0, 3'd0, 21'd0, 64'd0, 64'd0, 5'd1, 14'd0, "R10");

      // R9: wrap at the top and below zero
      drive(1, 2'd3, 3'd0, 21'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFC, 5'd1, 14'd0, "R9");
      drive(1, 2'd0, 3'd0, 21'd0, 64'd0, 64'd0, 5'd1, 14'd0, "R9");
      drive(1, 2'd2, 3'd0, -21'sd2, 64'd0, 64'd0, 5'd1, 14'd0, "R9");
      drive(0, 2'd0, 3'd0, 21'd0, 64'd0, 64'd0, 5'd1, 14'd0, "R9");

      wait (sb_q.size() == 0);
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule